// File: doc/BRIEF.md
# Dual-Master Hardware Semaphore Bank

A bank of hardware semaphores that two bus masters use to guard shared resources: a host CPU and a coprocessor. Each semaphore is in one of three states: free, held by the host, or held by the coprocessor. A master can only release a semaphore that it holds itself.

The host sees the bank as one register that is twice as wide as the bank. The upper half is a write-enable mask with one bit per semaphore. The lower half holds the semaphore bits. A host write acts only on the semaphores whose mask bit is set in that same write. The coprocessor has its own request port. A request carries an index and a lock-or-release flag, and a lock request gets a grant flag back in the same cycle. If both masters try to lock the same free semaphore in the same cycle, the host wins. A status vector shows which semaphores the coprocessor holds.

Top module: `sema_bank`

## Requirements
- R1: After reset every semaphore is free, so `host_rdata` reads 0 and `cop_owned` reads 0.
- R2: `host_rdata` bits 15..8 always read 0. Bit n (0..7) reads 1 exactly when the host holds semaphore n.
- R3: A host write leaves semaphore n unchanged when `host_wdata` bit n+8 (its mask bit) is 0.
- R4: A host write with mask bit n+8 = 1 and data bit n = 1 gives semaphore n to the host from the next cycle on, but only if semaphore n was free.
- R5: A host write with mask bit n+8 = 1 and data bit n = 0 frees semaphore n only if the host held it. A semaphore held by the coprocessor stays held.
- R6: A coprocessor lock request (`cop_req`=1, `cop_lock`=1) sets `cop_ok` in that same cycle if the indexed semaphore is free or is already held by the coprocessor. The semaphore is then held by the coprocessor from the next cycle on.
- R7: A coprocessor lock request on a semaphore held by the host gives `cop_ok`=0 and changes nothing.
- R8: A coprocessor release request (`cop_req`=1, `cop_lock`=0) frees the indexed semaphore only if the coprocessor holds it. `cop_ok` stays 0 during a release.
- R9: If a host lock and a coprocessor lock hit the same free semaphore in the same cycle, the host gets it and `cop_ok` is 0.
- R10: Bit n of `cop_owned` is 1 exactly when the coprocessor holds semaphore n. It is never 1 at the same time as bit n of `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 16 | Mask in bits 15..8, semaphore values in bits 7..0 |
| host_rdata | output | 16 | Host readback; shows host-held semaphores only |
| cop_req | input | 1 | Coprocessor request valid |
| cop_lock | input | 1 | 1 = lock request, 0 = release request |
| cop_idx | input | 3 | Semaphore index of the request |
| cop_ok | output | 1 | Same-cycle grant for a lock request |
| cop_owned | output | 8 | Semaphores held by the coprocessor |

## Verification
Ownership changes appear one clock after the host write or coprocessor request that causes them, since the state of each semaphore sits in a single register and both readbacks are decoded straight from it. `cop_ok` is combinational, so it is due in the same cycle as its request. The bench drives inputs on the falling edge. It samples `cop_ok` shortly after driving, before the next rising edge. It reads `host_rdata` and `cop_owned` at the falling edge that follows that rising edge.

// File: rtl/sema_pkg.sv
package sema_pkg;
   typedef enum logic [1:0] {
      SEM_FREE = 2'd0,
      SEM_HOST = 2'd1,
      SEM_COP  = 2'd2
   } sem_own_e;
endpackage

// File: rtl/sema_host_dec.sv
module sema_host_dec #(
   parameter int NUM_SEM = 8,
   localparam int HW = 2 * NUM_SEM
) (
   input  logic               wr,
   input  logic [HW-1:0]      wdata,
   output logic [NUM_SEM-1:0] lock_req,
   output logic [NUM_SEM-1:0] free_req
);
   for (genvar n = 0; n < NUM_SEM; n++) begin : g_bit
      logic en;
      assign en          = wr & wdata[NUM_SEM + n];
      assign lock_req[n] = en &  wdata[n];
      assign free_req[n] = en & ~wdata[n];
   end
endmodule

// File: rtl/sema_cop_dec.sv
module sema_cop_dec #(
   parameter int NUM_SEM = 8,
   localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
   input  logic               req,
   input  logic               lock,
   input  logic [IDX_W-1:0]   idx,
   output logic [NUM_SEM-1:0] lock_req,
   output logic [NUM_SEM-1:0] free_req
);
   for (genvar n = 0; n < NUM_SEM; n++) begin : g_sel
      logic hit;
      assign hit         = req & (idx == IDX_W'(n));
      assign lock_req[n] = hit &  lock;
      assign free_req[n] = hit & ~lock;
   end
endmodule

// File: rtl/sema_cell.sv
module sema_cell
   import sema_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     h_lock,
   input  logic     h_free,
   input  logic     c_lock,
   input  logic     c_free,
   output sem_own_e own,
   output logic     c_grant
);
   sem_own_e own_nx;

   always_comb begin
      own_nx = own;
      unique case (own)
         SEM_FREE: if (h_lock) own_nx = SEM_HOST;
                   else if (c_lock) own_nx = SEM_COP;
         SEM_HOST: if (h_free) own_nx = SEM_FREE;
         SEM_COP:  if (c_free) own_nx = SEM_FREE;
         default:  own_nx = SEM_FREE;
      endcase
   end

   assign c_grant = c_lock & ((own == SEM_COP) | ((own == SEM_FREE) & ~h_lock));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) own <= SEM_FREE;
      else        own <= own_nx;
   end

   // R9: host lock on a free semaphore always wins
   a_r9_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (own == SEM_FREE && h_lock) |=> own == SEM_HOST);
   // R6: a granted coprocessor lock yields coprocessor ownership
   a_r6_grant_owns: assert property (@(posedge clk) disable iff (!rst_n)
      c_grant |=> own == SEM_COP);
   // R5: host cannot take or free a coprocessor-held semaphore
   a_r5_cop_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (own == SEM_COP && !c_free) |=> own == SEM_COP);
   // R3: no request leaves the state unchanged
   a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!h_lock && !h_free && !c_lock && !c_free) |=> $stable(own));
endmodule

// File: rtl/sema_bank.sv
module sema_bank
   import sema_pkg::*;
#(
   parameter int NUM_SEM = 8,
   localparam int HW    = 2 * NUM_SEM,
   localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [HW-1:0]      host_wdata,
   output logic [HW-1:0]      host_rdata,
   input  logic               cop_req,
   input  logic               cop_lock,
   input  logic [IDX_W-1:0]   cop_idx,
   output logic               cop_ok,
   output logic [NUM_SEM-1:0] cop_owned
);
   if (NUM_SEM < 1) begin : g_bad_cfg
      $error("sema_bank: NUM_SEM must be at least 1");
   end

   logic [NUM_SEM-1:0] h_lock, h_free, c_lock, c_free, grant, host_own;

   sema_host_dec #(.NUM_SEM(NUM_SEM)) u_host (
      .wr(host_wr), .wdata(host_wdata), .lock_req(h_lock), .free_req(h_free));

   sema_cop_dec #(.NUM_SEM(NUM_SEM)) u_cop (
      .req(cop_req), .lock(cop_lock), .idx(cop_idx),
      .lock_req(c_lock), .free_req(c_free));

   for (genvar n = 0; n < NUM_SEM; n++) begin : g_sem
      sem_own_e own;
      sema_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .h_lock(h_lock[n]), .h_free(h_free[n]),
         .c_lock(c_lock[n]), .c_free(c_free[n]),
         .own(own), .c_grant(grant[n]));
      assign host_own[n]  = (own == SEM_HOST);
      assign cop_owned[n] = (own == SEM_COP);
   end

   assign host_rdata = {{NUM_SEM{1'b0}}, host_own};
   assign cop_ok     = |grant;

   // R2: mask half reads zero
   a_r2_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[HW-1:NUM_SEM] == '0);
   // R10: the two owner views never overlap
   a_r10_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata[NUM_SEM-1:0] & cop_owned) == '0);
   // R8: a release request never reports a grant
   a_r8_no_ok_free: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_req && !cop_lock) |-> !cop_ok);
   // R7: a host-held semaphore stays host-held under coprocessor requests alone
   a_r7_host_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr && cop_req) |=> (host_rdata == $past(host_rdata)));
endmodule

// File: tb/tb_sema_bank.sv
module tb_sema_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        cop_req = 1'b0;
   logic        cop_lock = 1'b0;
   logic [2:0]  cop_idx = '0;
   logic        cop_ok;
   logic [7:0]  cop_owned;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sema_bank dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .cop_req(cop_req), .cop_lock(cop_lock),
      .cop_idx(cop_idx), .cop_ok(cop_ok), .cop_owned(cop_owned));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag, input logic [15:0] exp_h, input logic [7:0] exp_c);
      check({tag, " host_rdata"}, host_rdata, exp_h);
      check({tag, " cop_owned"}, {8'h00, cop_owned}, {8'h00, exp_c});
      check("R10 disjoint", {8'h00, host_rdata[7:0] & cop_owned}, 16'h0000);
   endtask

   task automatic host_write(input logic [15:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_wdata = '0;
   endtask

   task automatic cop_op(input logic lk, input logic [2:0] idx, output logic ok);
      @(negedge clk);
      cop_req = 1'b1; cop_lock = lk; cop_idx = idx;
      #1 ok = cop_ok;
      @(negedge clk);
      cop_req = 1'b0;
   endtask

   task automatic t_reset;
      check_state("R1 reset", 16'h0000, 8'h00);
   endtask

   task automatic t_host_lock;
      host_write(16'hFF05);
      check_state("R4 R2 host lock", 16'h0005, 8'h00);
   endtask

   task automatic t_mask;
      host_write(16'h0002);
      check_state("R3 mask off", 16'h0005, 8'h00);
      host_write(16'h0300);
      check_state("R3 R5 masked release", 16'h0004, 8'h00);
   endtask

   task automatic t_cop_set;
      logic ok;
      cop_op(1'b1, 3'd3, ok);
      check("R6 set free ok", {15'd0, ok}, 16'd1);
      check_state("R6 set free", 16'h0004, 8'h08);
      cop_op(1'b1, 3'd3, ok);
      check("R6 set again ok", {15'd0, ok}, 16'd1);
      cop_op(1'b1, 3'd2, ok);
      check("R7 set host-held ok", {15'd0, ok}, 16'd0);
      check_state("R7 set host-held", 16'h0004, 8'h08);
   endtask

   task automatic t_host_vs_cop;
      host_write(16'h0808);
      check_state("R4 lock cop-held", 16'h0004, 8'h08);
      host_write(16'h0800);
      check_state("R5 free cop-held", 16'h0004, 8'h08);
   endtask

   task automatic t_cop_clr;
      logic ok;
      cop_op(1'b0, 3'd2, ok);
      check("R8 release host-held ok", {15'd0, ok}, 16'd0);
      check_state("R8 release host-held", 16'h0004, 8'h08);
      cop_op(1'b0, 3'd3, ok);
      check("R8 release own ok", {15'd0, ok}, 16'd0);
      check_state("R8 release own", 16'h0004, 8'h00);
   endtask

   task automatic t_conflict;
      logic ok;
      @(negedge clk);
      host_wr = 1'b1; host_wdata = 16'h2020;
      cop_req = 1'b1; cop_lock = 1'b1; cop_idx = 3'd5;
      #1 ok = cop_ok;
      @(negedge clk);
      host_wr = 1'b0; host_wdata = '0; cop_req = 1'b0;
      check("R9 conflict ok", {15'd0, ok}, 16'd0);
      check_state("R9 conflict", 16'h0024, 8'h00);
   endtask

   task automatic t_both_owners;
      logic ok;
      cop_op(1'b1, 3'd7, ok);
      check("R6 set idx7 ok", {15'd0, ok}, 16'd1);
      host_write(16'hFFFF);
      check_state("R10 both owners", 16'h007F, 8'h80);
      host_write(16'hFF00);
      check_state("R5 release all", 16'h0000, 8'h80);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_host_lock();
      t_mask();
      t_cop_set();
      t_host_vs_cop();
      t_cop_clr();
      t_conflict();
      t_both_owners();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule